// File: doc/BRIEF.md
# Indexed-Window Control and Status Register Bank

A memory-mapped bank of control and status registers with 32-bit data and byte addresses, served over a simple single-cycle bus: a request carries an address, a write flag, write data and per-byte strobes, and the same cycle returns read data and an error flag. The bank holds plain read/write words, read-only words fed from input ports, a replicated group of mixed read-only/read-write registers, flag bits that software clears or sets by writing a chosen polarity, and two guarded fields whose writability depends on a gate bit elsewhere in the map.

A 2x4 array of registers is reached through a single shared window offset. The entry the window shows is selected by the two 16-bit index fields at offset 0x00 and the gate bit at offset 0x08. When the gate is closed or the indices point outside the array, the window reports an error. Every writable value is driven out on an output port, and every read-only value is sampled from an input port at read time.

Top module: `csr_bank_idx`

## Requirements
- R1: After reset every writable field and every flag is 0, so all field outputs read 0.
- R2: Offset 0x00 holds the row index in bits 31:16 and the column index in bits 15:0; 0x04 is a full 32-bit read/write word; bit 0 of 0x08 is the read/write gate bit. Bits that are not defined read as 0.
- R3: A write changes only the bytes whose strobe bit is 1, strobe bit k covering data bits 8k+7..8k.
- R4: Offset 0x0C reads the 32-bit input `ro_word_i`, and bit 16 of 0x08 reads the input `ro_bit_i`; writes to these bits have no effect.
- R5: Four replicated registers sit at 0x10 + 4*n; in register n bits 31:16 read `rep_ro_i[16n+15:16n]` and bits 15:0 are read/write, driven on `rep_rw_o[16n+15:16n]`.
- R6: Offset 0x20 reaches entry k = 4*row + col of the array only while the gate bit is 1, the row index is below 2 and the column index is below 4; its bits 31:16 read `arr_ro_i[16k+15:16k]` and bits 15:0 are read/write on `arr_rw_o[16k+15:16k]`.
- R7: At 0x24, bit 0 (`clr_flags_o[0]`) clears when a 1 is written to it and bit 8 (`clr_flags_o[1]`) clears when a 0 is written to it; `hw_set_i[0]`/`hw_set_i[1]` set them, and the hardware set wins over a software clear in the same cycle.
- R8: At 0x28, bit 0 (`set_flags_o[0]`) sets when a 1 is written and bit 8 (`set_flags_o[1]`) sets when a 0 is written; `hw_clr_i[0]`/`hw_clr_i[1]` clear them, and the hardware clear wins in the same cycle.
- R9: Bits 31:16 at 0x2C (`lock_fld_o`) ignore writes while the gate bit is 1.
- R10: Bits 15:0 at 0x2C (`en_fld_o`) accept writes only while the gate bit is 1.
- R11: An access to an unaligned or unmapped offset, or to 0x20 with no matching array entry, returns read data 0, raises `err` in the same cycle, and changes no state; `err` is 0 when `req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request |
| we | input | 1 | 1 for write, 0 for read |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data |
| strb | input | 4 | Byte strobes |
| rdata | output | 32 | Read data, valid in the request cycle |
| err | output | 1 | Access error, in the request cycle |
| ro_word_i | input | 32 | Read-only word at 0x0C |
| ro_bit_i | input | 1 | Read-only bit 16 at 0x08 |
| rep_ro_i | input | 16*REP_N | Upper halves of the replicated registers |
| arr_ro_i | input | 16*ROWS*COLS | Upper halves of the array entries |
| hw_set_i | input | 2 | Hardware set pulses for the 0x24 flags |
| hw_clr_i | input | 2 | Hardware clear pulses for the 0x28 flags |
| row_idx_o | output | 16 | Row index field |
| col_idx_o | output | 16 | Column index field |
| word_o | output | 32 | Read/write word at 0x04 |
| gate_o | output | 1 | Gate bit |
| rep_rw_o | output | 16*REP_N | Lower halves of the replicated registers |
| arr_rw_o | output | 16*ROWS*COLS | Lower halves of the array entries |
| clr_flags_o | output | 2 | Software-clearable flags (bit 8, bit 0) |
| set_flags_o | output | 2 | Software-settable flags (bit 8, bit 0) |
| lock_fld_o | output | 16 | Lock-guarded field |
| en_fld_o | output | 16 | Enable-guarded field |

## Verification
The bench builds the bank with its defaults, REP_N of 4 and a 2x4 array, so every replicated slot and every array entry is addressable. Index values written to 0x00 are drawn from 0..2 for the row and 0..4 for the column, one past each bound, which brings the window's no-match error within reach alongside every valid entry, while the gate bit is toggled at random so the guarded fields see both states.

// File: rtl/csrb_pkg.sv
`timescale 1ns/1ps
package csrb_pkg;
    localparam int DATA_W = 32;
    localparam int STRB_W = DATA_W / 8;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_IDX,
        SEL_WORD,
        SEL_GATE,
        SEL_ROWORD,
        SEL_REP,
        SEL_ARR,
        SEL_CLRF,
        SEL_SETF,
        SEL_GUARD
    } sel_e;

    // Replace strobed bytes of old_v with those of new_v.
    function automatic logic [DATA_W-1:0] byte_merge(
        input logic [DATA_W-1:0] old_v,
        input logic [DATA_W-1:0] new_v,
        input logic [STRB_W-1:0] be
    );
        logic [DATA_W-1:0] res;
        for (int b = 0; b < STRB_W; b++) begin
            res[8*b +: 8] = be[b] ? new_v[8*b +: 8] : old_v[8*b +: 8];
        end
        return res;
    endfunction
endpackage

// File: rtl/csrb_decode.sv
`timescale 1ns/1ps
module csrb_decode
    import csrb_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int REP_N  = 4,
    localparam int REP_IW = (REP_N > 1) ? $clog2(REP_N) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output sel_e              sel,
    output logic [REP_IW-1:0] rep_idx
);
    localparam int REP_BASE = 'h10;

    always_comb begin
        int unsigned ofs;
        ofs     = 32'(addr);
        sel     = SEL_NONE;
        rep_idx = '0;
        if (addr[1:0] == 2'b00) begin
            if (ofs == 'h00)      sel = SEL_IDX;
            else if (ofs == 'h04) sel = SEL_WORD;
            else if (ofs == 'h08) sel = SEL_GATE;
            else if (ofs == 'h0C) sel = SEL_ROWORD;
            else if (ofs >= REP_BASE && ofs < REP_BASE + 4 * REP_N) begin
                sel     = SEL_REP;
                rep_idx = REP_IW'((ofs - REP_BASE) >> 2);
            end
            else if (ofs == 'h20) sel = SEL_ARR;
            else if (ofs == 'h24) sel = SEL_CLRF;
            else if (ofs == 'h28) sel = SEL_SETF;
            else if (ofs == 'h2C) sel = SEL_GUARD;
        end
    end
endmodule

// File: rtl/csrb_arr_sel.sv
`timescale 1ns/1ps
module csrb_arr_sel #(
    parameter int ROWS = 2,
    parameter int COLS = 4,
    localparam int N   = ROWS * COLS,
    localparam int KW  = (N > 1) ? $clog2(N) : 1
) (
    input  logic          gate,
    input  logic [15:0]   row_sel,
    input  logic [15:0]   col_sel,
    output logic          hit,
    output logic [KW-1:0] k
);
    logic [N-1:0] match;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            assign match[r*COLS + c] = gate && (row_sel == 16'(r)) && (col_sel == 16'(c));
        end
    end

    always_comb begin
        hit = |match;
        k   = '0;
        for (int n = 0; n < N; n++) begin
            if (match[n]) k = KW'(n);
        end
    end
endmodule

// File: rtl/csr_bank_idx.sv
`timescale 1ns/1ps
module csr_bank_idx
    import csrb_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int REP_N  = 4,
    parameter int ROWS   = 2,
    parameter int COLS   = 4,
    localparam int ARR_N  = ROWS * COLS,
    localparam int REP_IW = (REP_N > 1) ? $clog2(REP_N) : 1,
    localparam int ARR_KW = (ARR_N > 1) ? $clog2(ARR_N) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req,
    input  logic                  we,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    input  logic [STRB_W-1:0]     strb,
    output logic [DATA_W-1:0]     rdata,
    output logic                  err,
    input  logic [31:0]           ro_word_i,
    input  logic                  ro_bit_i,
    input  logic [16*REP_N-1:0]   rep_ro_i,
    input  logic [16*ARR_N-1:0]   arr_ro_i,
    input  logic [1:0]            hw_set_i,
    input  logic [1:0]            hw_clr_i,
    output logic [15:0]           row_idx_o,
    output logic [15:0]           col_idx_o,
    output logic [31:0]           word_o,
    output logic                  gate_o,
    output logic [16*REP_N-1:0]   rep_rw_o,
    output logic [16*ARR_N-1:0]   arr_rw_o,
    output logic [1:0]            clr_flags_o,
    output logic [1:0]            set_flags_o,
    output logic [15:0]           lock_fld_o,
    output logic [15:0]           en_fld_o
);
    typedef struct packed {
        logic [15:0]             row_idx;
        logic [15:0]             col_idx;
        logic [31:0]             word;
        logic                    gate;
        logic [REP_N-1:0][15:0]  rep;
        logic [ARR_N-1:0][15:0]  arr;
        logic [1:0]              clrf;
        logic [1:0]              setf;
        logic [15:0]             lock_f;
        logic [15:0]             en_f;
    } state_t;

    state_t state_d, state_q;

    sel_e              sel;
    logic [REP_IW-1:0] rep_idx;
    logic              arr_hit;
    logic [ARR_KW-1:0] arr_k;

    csrb_decode #(.ADDR_W(ADDR_W), .REP_N(REP_N)) u_decode (
        .addr    (addr),
        .sel     (sel),
        .rep_idx (rep_idx)
    );

    csrb_arr_sel #(.ROWS(ROWS), .COLS(COLS)) u_arr_sel (
        .gate    (state_q.gate),
        .row_sel (state_q.row_idx),
        .col_sel (state_q.col_idx),
        .hit     (arr_hit),
        .k       (arr_k)
    );

    always_comb begin
        logic [DATA_W-1:0] rd_word;
        logic [DATA_W-1:0] wm;
        logic              miss;
        logic              wr;

        state_d = state_q;
        rd_word = '0;
        miss    = 1'b0;

        case (sel)
            SEL_IDX:    rd_word = {state_q.row_idx, state_q.col_idx};
            SEL_WORD:   rd_word = state_q.word;
            SEL_GATE:   rd_word = {15'd0, ro_bit_i, 15'd0, state_q.gate};
            SEL_ROWORD: rd_word = ro_word_i;
            SEL_REP:    rd_word = {rep_ro_i[16*rep_idx +: 16], state_q.rep[rep_idx]};
            SEL_ARR: begin
                if (arr_hit) rd_word = {arr_ro_i[16*arr_k +: 16], state_q.arr[arr_k]};
                else         miss    = 1'b1;
            end
            SEL_CLRF:   rd_word = {23'd0, state_q.clrf[1], 7'd0, state_q.clrf[0]};
            SEL_SETF:   rd_word = {23'd0, state_q.setf[1], 7'd0, state_q.setf[0]};
            SEL_GUARD:  rd_word = {state_q.lock_f, state_q.en_f};
            default:    miss    = 1'b1;
        endcase

        err   = req && miss;
        rdata = (req && !miss) ? rd_word : '0;
        wm    = byte_merge(rd_word, wdata, strb);
        wr    = req && we && !miss;

        if (wr) begin
            case (sel)
                SEL_IDX: begin
                    state_d.row_idx = wm[31:16];
                    state_d.col_idx = wm[15:0];
                end
                SEL_WORD: state_d.word = wm;
                SEL_GATE: state_d.gate = wm[0];
                SEL_REP:  state_d.rep[rep_idx] = wm[15:0];
                SEL_ARR:  state_d.arr[arr_k]   = wm[15:0];
                SEL_CLRF: begin
                    if (strb[0] && wdata[0])  state_d.clrf[0] = 1'b0;
                    if (strb[1] && !wdata[8]) state_d.clrf[1] = 1'b0;
                end
                SEL_SETF: begin
                    if (strb[0] && wdata[0])  state_d.setf[0] = 1'b1;
                    if (strb[1] && !wdata[8]) state_d.setf[1] = 1'b1;
                end
                SEL_GUARD: begin
                    if (!state_q.gate) state_d.lock_f = wm[31:16];
                    if (state_q.gate)  state_d.en_f   = wm[15:0];
                end
                default: ;
            endcase
        end

        // hardware events take priority over software in the same cycle
        state_d.clrf = state_d.clrf | hw_set_i;
        state_d.setf = state_d.setf & ~hw_clr_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign row_idx_o   = state_q.row_idx;
    assign col_idx_o   = state_q.col_idx;
    assign word_o      = state_q.word;
    assign gate_o      = state_q.gate;
    assign rep_rw_o    = state_q.rep;
    assign arr_rw_o    = state_q.arr;
    assign clr_flags_o = state_q.clrf;
    assign set_flags_o = state_q.setf;
    assign lock_fld_o  = state_q.lock_f;
    assign en_fld_o    = state_q.en_f;
endmodule

// File: rtl/csrb_checker.sv
`timescale 1ns/1ps
module csrb_checker #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic              we,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic [3:0]        strb,
    input logic [31:0]       rdata,
    input logic              err,
    input logic [31:0]       ro_word_i,
    input logic [1:0]        hw_set_i,
    input logic [1:0]        hw_clr_i,
    input logic              gate_o,
    input logic [1:0]        clr_flags_o,
    input logic [1:0]        set_flags_o,
    input logic [15:0]       lock_fld_o,
    input logic [15:0]       en_fld_o
);
    a_r4_ro_word_read: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we && addr == ADDR_W'('h0C)) |-> (rdata == ro_word_i && !err));

    a_r6_window_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (req && addr == ADDR_W'('h20) && !gate_o) |-> err);

    a_r7_sw_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we && addr == ADDR_W'('h24) && strb[0] && wdata[0] && !hw_set_i[0])
        |=> !clr_flags_o[0]);

    a_r7_hw_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        hw_set_i[0] |=> clr_flags_o[0]);

    a_r8_hw_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        hw_clr_i[1] |=> !set_flags_o[1]);

    a_r9_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        gate_o |=> $stable(lock_fld_o));

    a_r10_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_o |=> $stable(en_fld_o));

    a_r11_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (rdata == 32'd0 && req));
endmodule

bind csr_bank_idx csrb_checker #(.ADDR_W(ADDR_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (req),
    .we          (we),
    .addr        (addr),
    .wdata       (wdata),
    .strb        (strb),
    .rdata       (rdata),
    .err         (err),
    .ro_word_i   (ro_word_i),
    .hw_set_i    (hw_set_i),
    .hw_clr_i    (hw_clr_i),
    .gate_o      (gate_o),
    .clr_flags_o (clr_flags_o),
    .set_flags_o (set_flags_o),
    .lock_fld_o  (lock_fld_o),
    .en_fld_o    (en_fld_o)
);

// File: tb/csr_bank_idx_tb_top.sv
`timescale 1ns/100ps
module csr_bank_idx_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req = 1'b0;
    logic         we = 1'b0;
    logic [7:0]   addr = '0;
    logic [31:0]  wdata = '0;
    logic [3:0]   strb = '0;
    logic [31:0]  rdata;
    logic         err;
    logic [31:0]  ro_word_i = '0;
    logic         ro_bit_i = 1'b0;
    logic [63:0]  rep_ro_i = '0;
    logic [127:0] arr_ro_i = '0;
    logic [1:0]   hw_set_i = '0;
    logic [1:0]   hw_clr_i = '0;
    logic [15:0]  row_idx_o, col_idx_o, lock_fld_o, en_fld_o;
    logic [31:0]  word_o;
    logic         gate_o;
    logic [63:0]  rep_rw_o;
    logic [127:0] arr_rw_o;
    logic [1:0]   clr_flags_o, set_flags_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // reference state
    logic [15:0]       m_row, m_col, m_lock, m_en;
    logic [31:0]       m_word;
    logic              m_gate;
    logic [3:0][15:0]  m_rep;
    logic [7:0][15:0]  m_arr;
    logic [1:0]        m_clr, m_set;

    always #2 clk = ~clk;

    csr_bank_idx dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
        .wdata(wdata), .strb(strb), .rdata(rdata), .err(err),
        .ro_word_i(ro_word_i), .ro_bit_i(ro_bit_i), .rep_ro_i(rep_ro_i),
        .arr_ro_i(arr_ro_i), .hw_set_i(hw_set_i), .hw_clr_i(hw_clr_i),
        .row_idx_o(row_idx_o), .col_idx_o(col_idx_o), .word_o(word_o),
        .gate_o(gate_o), .rep_rw_o(rep_rw_o), .arr_rw_o(arr_rw_o),
        .clr_flags_o(clr_flags_o), .set_flags_o(set_flags_o),
        .lock_fld_o(lock_fld_o), .en_fld_o(en_fld_o)
    );

    task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [7:0] a);
        case (a)
            8'h00, 8'h04: return "R2 plain rw";
            8'h08:        return "R2/R4 gate word";
            8'h0C:        return "R4 ro word";
            8'h10, 8'h14, 8'h18, 8'h1C: return "R5 replicated";
            8'h20:        return "R6 window";
            8'h24:        return "R7 clear flags";
            8'h28:        return "R8 set flags";
            8'h2C:        return "R9/R10 guarded";
            default:      return "R11 unmapped";
        endcase
    endfunction

    function automatic void exp_read(input logic [7:0] a, output logic [31:0] rd, output logic er);
        rd = '0;
        er = 1'b0;
        case (a)
            8'h00: rd = {m_row, m_col};
            8'h04: rd = m_word;
            8'h08: rd = {15'd0, ro_bit_i, 15'd0, m_gate};
            8'h0C: rd = ro_word_i;
            8'h10, 8'h14, 8'h18, 8'h1C: rd = {rep_ro_i[16*((a-8'h10)>>2) +: 16], m_rep[(a-8'h10)>>2]};
            8'h20: begin
                if (m_gate && m_row < 16'd2 && m_col < 16'd4)
                    rd = {arr_ro_i[16*(m_row*4+m_col) +: 16], m_arr[m_row*4+m_col]};
                else
                    er = 1'b1;
            end
            8'h24: rd = {23'd0, m_clr[1], 7'd0, m_clr[0]};
            8'h28: rd = {23'd0, m_set[1], 7'd0, m_set[0]};
            8'h2C: rd = {m_lock, m_en};
            default: er = 1'b1;
        endcase
    endfunction

    function automatic logic [31:0] mrg(input logic [31:0] o, input logic [31:0] n, input logic [3:0] s);
        logic [31:0] r;
        for (int b = 0; b < 4; b++) r[8*b +: 8] = s[b] ? n[8*b +: 8] : o[8*b +: 8];
        return r;
    endfunction

    function automatic void model_write(input logic [7:0] a, input logic [31:0] wd, input logic [3:0] s, input logic [31:0] old);
        logic [31:0] w;
        w = mrg(old, wd, s);
        case (a)
            8'h00: begin m_row = w[31:16]; m_col = w[15:0]; end
            8'h04: m_word = w;
            8'h08: m_gate = w[0];
            8'h10, 8'h14, 8'h18, 8'h1C: m_rep[(a-8'h10)>>2] = w[15:0];
            8'h20: m_arr[m_row*4+m_col] = w[15:0];
            8'h24: begin
                if (s[0] && wd[0])  m_clr[0] = 1'b0;
                if (s[1] && !wd[8]) m_clr[1] = 1'b0;
            end
            8'h28: begin
                if (s[0] && wd[0])  m_set[0] = 1'b1;
                if (s[1] && !wd[8]) m_set[1] = 1'b1;
            end
            8'h2C: begin
                if (!m_gate) m_lock = w[31:16];
                if (m_gate)  m_en   = w[15:0];
            end
            default: ;
        endcase
    endfunction

    task automatic check_state(input string tag);
        logic [127:0] act, exp;
        act = {row_idx_o, col_idx_o, word_o, gate_o, clr_flags_o, set_flags_o, lock_fld_o, en_fld_o};
        exp = {m_row, m_col, m_word, m_gate, m_clr, m_set, m_lock, m_en};
        check(act == exp, tag, act, exp);
        check(rep_rw_o == m_rep, {tag, " R5 rep outputs"}, 128'(rep_rw_o), 128'(m_rep));
        check(arr_rw_o == m_arr, {tag, " R6 array outputs"}, arr_rw_o, m_arr);
    endtask

    task automatic access(input logic [7:0] a, input logic w, input logic [31:0] wd,
                          input logic [3:0] s, input logic [1:0] hs, input logic [1:0] hc);
        logic [31:0] er_d;
        logic        er_e;
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = wd; strb = s;
        hw_set_i = hs; hw_clr_i = hc;
        ro_word_i = $urandom; ro_bit_i = 1'($urandom);
        rep_ro_i = {$urandom, $urandom};
        arr_ro_i = {$urandom, $urandom, $urandom, $urandom};
        #0.5;
        exp_read(a, er_d, er_e);
        check(rdata == er_d && err == er_e, tag_of(a), {rdata, err}, {er_d, er_e});
        @(posedge clk);
        if (w && !er_e) model_write(a, wd, s, er_d);
        m_clr = m_clr | hs;
        m_set = m_set & ~hc;
        #0.5;
        req = 1'b0; we = 1'b0; hw_set_i = '0; hw_clr_i = '0;
        check_state({tag_of(a), " state"});
    endtask

    localparam logic [7:0] ADDRS [16] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C,
                                         8'h20, 8'h20, 8'h24, 8'h28, 8'h2C, 8'h30, 8'h06, 8'h7C};

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd12345);
        m_row = '0; m_col = '0; m_lock = '0; m_en = '0; m_word = '0; m_gate = 1'b0;
        m_rep = '0; m_arr = '0; m_clr = '0; m_set = '0;
        repeat (3) @(posedge clk);
        #0.5 rst_n = 1'b1;
        #0.5;
        // R1: reset state visible at the outputs
        check_state("R1 reset");
        check(err == 1'b0 && rdata == 32'd0, "R11 idle no err", {rdata, err}, 33'd0);

        // R3: byte strobes
        access(8'h04, 1'b1, 32'hFFFF_FFFF, 4'hF, 2'b00, 2'b00);
        access(8'h04, 1'b1, 32'h1122_3344, 4'b0101, 2'b00, 2'b00);
        check(word_o == 32'hFF22_FF44, "R3 strobe merge", 128'(word_o), 128'(32'hFF22_FF44));

        // R4: write to read-only word has no effect on any state
        access(8'h0C, 1'b1, 32'hDEAD_BEEF, 4'hF, 2'b00, 2'b00);

        // R11: unmapped write leaves state unchanged
        access(8'h30, 1'b1, 32'hFFFF_FFFF, 4'hF, 2'b00, 2'b00);

        // R6: window closed, then open on entry (1,3)
        access(8'h20, 1'b1, 32'h0000_ABCD, 4'hF, 2'b00, 2'b00);
        access(8'h00, 1'b1, 32'h0001_0003, 4'hF, 2'b00, 2'b00);
        access(8'h08, 1'b1, 32'h0000_0001, 4'hF, 2'b00, 2'b00);
        access(8'h20, 1'b1, 32'h0000_ABCD, 4'hF, 2'b00, 2'b00);
        check(arr_rw_o[16*7 +: 16] == 16'hABCD, "R6 entry 7 written", 128'(arr_rw_o[16*7 +: 16]), 128'(16'hABCD));

        // R9/R10: gate is 1 here
        access(8'h2C, 1'b1, 32'h1234_5678, 4'hF, 2'b00, 2'b00);
        check(lock_fld_o == 16'h0 && en_fld_o == 16'h5678, "R9/R10 gate=1",
              {lock_fld_o, en_fld_o}, {16'h0, 16'h5678});
        access(8'h08, 1'b1, 32'h0, 4'hF, 2'b00, 2'b00);
        access(8'h2C, 1'b1, 32'h9ABC_0000, 4'hF, 2'b00, 2'b00);
        check(lock_fld_o == 16'h9ABC && en_fld_o == 16'h5678, "R9/R10 gate=0",
              {lock_fld_o, en_fld_o}, {16'h9ABC, 16'h5678});

        // R7: hardware set beats software clear
        access(8'h24, 1'b0, 32'h0, 4'h0, 2'b11, 2'b00);
        access(8'h24, 1'b1, 32'h0000_0001, 4'hF, 2'b01, 2'b00);
        check(clr_flags_o == 2'b01, "R7 hw set wins / w0 clears bit 8", 128'(clr_flags_o), 128'(2'b01));

        // R8: hardware clear beats software set
        access(8'h28, 1'b1, 32'h0000_0001, 4'hF, 2'b00, 2'b01);
        check(set_flags_o == 2'b10, "R8 hw clear wins / w0 sets bit 8", 128'(set_flags_o), 128'(2'b10));

        // random mix
        for (int it = 0; it < 4000; it++) begin
            logic [7:0]  a;
            logic [31:0] wd;
            a  = ADDRS[$urandom_range(15)];
            wd = $urandom;
            if (a == 8'h00) wd = {16'($urandom_range(2)), 16'($urandom_range(4))};
            access(a, 1'($urandom), wd, 4'($urandom),
                   ($urandom_range(3) == 0) ? 2'($urandom) : 2'b00,
                   ($urandom_range(3) == 0) ? 2'($urandom) : 2'b00);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule